// File: doc/BRIEF.md
# Isochronous Packet Frame Delimiter

This block watches a byte stream cut into isochronous packets and marks where video frames begin and end, so that a downstream frame assembler can close one frame buffer and open the next. Each payload byte arrives with packet start and end flags. A packet with no payload bytes arrives as a single pulse on a separate input. A mode input picks one of two boundary rules. In compressed mode a frame starts at every packet that opens with the start-of-image marker 0xFF 0xD8. In uncompressed mode a zero-length packet ends the frame.

Each output beat can carry a close event (last packet of the old frame), an open event (first packet of the new frame) and one payload byte. The order inside a beat is fixed: close, then open, then the byte. In compressed mode an open also raises a request to insert a locally built stream header, and the two marker bytes are removed from the payload. That header carries the tables the compressed stream lacks. The stream itself is planar: start-of-image, frame header, restart definition, three scans for Y, U and V, then end-of-image. Only its leading marker matters here.

Bytes of one packet arrive on consecutive cycles. The mode changes only between packets.

Top module: `fd_frame_delim`

## Requirements
- R1: While reset is asserted and after it is released, every output is 0. Reset also clears any pending end-of-frame state, so a packet sent after reset opens no frame.
- R2: A byte presented in input cycle k appears on out_data with out_valid in cycle k+2. Bytes keep their order and their values, and no byte is created.
- R3: In compressed mode (compress_en=1), a packet of two or more bytes whose bytes 0 and 1 are 0xFF and 0xD8 sets out_close, out_open and hdr_req together, in cycle k+2, where k is the cycle of its 0xFF.
- R4: Those two marker bytes are never forwarded. The packet's remaining bytes are forwarded in order from its third byte on.
- R5: In compressed mode, a packet that starts with 0xFF followed by anything other than 0xD8 is forwarded unchanged with no event. So is a one-byte packet of 0xFF, and so is a packet that starts with 0xD8.
- R6: In compressed mode, a zero-length packet produces no event and no byte.
- R7: In uncompressed mode, after a zero-length packet, the first byte of the next packet with bytes carries out_close and out_open in its own beat, with hdr_req low. The packet after that carries no event.
- R8: In uncompressed mode, several zero-length packets in a row produce exactly one close/open pair.
- R9: A change of compress_en discards a pending end-of-frame: a zero-length packet followed by a switch to compressed mode and back opens no frame.
- R10: In uncompressed mode, a packet starting 0xFF 0xD8 is forwarded whole, with no event.
- R11: In compressed mode, 0xFF 0xD8 anywhere other than at bytes 0 and 1 of a packet is forwarded, with no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| compress_en | input | 1 | 1 = compressed mode, 0 = uncompressed mode |
| in_valid | input | 1 | in_data holds a payload byte |
| in_data | input | DATA_W | Payload byte |
| in_sop | input | 1 | Byte is the first of its packet |
| in_eop | input | 1 | Byte is the last of its packet |
| in_empty | input | 1 | A zero-length packet completed (never together with in_valid) |
| out_valid | output | 1 | out_data holds a forwarded byte |
| out_data | output | DATA_W | Forwarded byte |
| out_close | output | 1 | Last-packet event: the current frame ends |
| out_open | output | 1 | First-packet event: a new frame starts |
| hdr_req | output | 1 | Insert the local stream header ahead of the new frame |

## Verification
Two internal states can go wrong: the pending end-of-frame flag and the held first byte. A flag that is wrongly set or never cleared shows up as an extra or missing close/open pair on the first byte of the next packet, two cycles after that byte enters. A fault in the marker compare or the drop mark shows up in the same beat as the packet's first byte, or in the beat after it. The symptom is a missing or extra 0xFF or 0xD8 on out_data, or an hdr_req that fires without its open. The bench compares every output beat against a packet-level model, so each such fault is caught within two cycles.

// File: rtl/fd_pkg.sv
package fd_pkg;

    // Attributes of the byte held in the look-ahead stage
    typedef struct packed {
        logic valid;
        logic sop;
        logic eop;
        logic empty;
        logic drop;
    } fd_tag_t;

    // One output beat, without its data
    typedef struct packed {
        logic close;
        logic open;
        logic hdr;
        logic valid;
    } fd_evt_t;

    // Boundary rule state
    typedef struct packed {
        logic mode;
        logic flag;
    } fd_ctl_t;

endpackage

// File: rtl/fd_stage.sv
module fd_stage #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_data,
    input  logic                  in_sop,
    input  logic                  in_eop,
    input  logic                  in_empty,
    input  logic                  drop_next,
    output fd_pkg::fd_tag_t       s_tag,
    output logic [DATA_W-1:0]     s_data
);
    import fd_pkg::*;

    fd_tag_t             tag_d, tag_q;
    logic [DATA_W-1:0]   dat_d, dat_q;

    always_comb begin
        tag_d.valid = in_valid;
        tag_d.sop   = in_valid && in_sop;
        tag_d.eop   = in_valid && in_eop;
        tag_d.empty = in_empty && !in_valid;
        // the byte now entering is the second marker byte when drop_next is high
        tag_d.drop  = drop_next;
        dat_d       = in_valid ? in_data : dat_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
            dat_q <= '0;
        end else begin
            tag_q <= tag_d;
            dat_q <= dat_d;
        end
    end

    assign s_tag  = tag_q;
    assign s_data = dat_q;

    // R6: a zero-length packet never occupies the stage as a byte
    p_empty_not_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tag_q.empty |-> !tag_q.valid);

endmodule

// File: rtl/fd_rules.sv
module fd_rules #(
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] SOI_HI = 8'hFF,
    parameter logic [DATA_W-1:0] SOI_LO = 8'hD8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  compress_en,
    input  fd_pkg::fd_tag_t       s_tag,
    input  logic [DATA_W-1:0]     s_data,
    input  logic                  in_valid,
    input  logic                  in_sop,
    input  logic [DATA_W-1:0]     in_data,
    output fd_pkg::fd_evt_t       evt,
    output logic                  drop_next
);
    import fd_pkg::*;

    fd_ctl_t ctl_d, ctl_q;
    logic    mode_chg;
    logic    soi_hit;
    logic    raw_hit;

    always_comb begin
        mode_chg = (compress_en != ctl_q.mode);

        // marker: first held byte is SOI_HI and the following byte of the same packet is SOI_LO
        soi_hit = ctl_q.mode && s_tag.valid && s_tag.sop && !s_tag.eop
                  && (s_data == SOI_HI)
                  && in_valid && !in_sop && (in_data == SOI_LO);

        // uncompressed: first byte of a packet after a pending empty packet
        raw_hit = !ctl_q.mode && s_tag.valid && s_tag.sop && ctl_q.flag;

        evt.close = soi_hit || raw_hit;
        evt.open  = soi_hit || raw_hit;
        evt.hdr   = soi_hit;
        evt.valid = s_tag.valid && !s_tag.drop && !soi_hit;

        ctl_d.mode = compress_en;
        ctl_d.flag = ctl_q.flag;
        if (s_tag.empty) ctl_d.flag = 1'b1;
        if (raw_hit)     ctl_d.flag = 1'b0;
        if (mode_chg)    ctl_d.flag = 1'b0;
    end

    assign drop_next = soi_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R3: header request only in compressed mode
    p_hdr_only_compressed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt.hdr |-> ctl_q.mode);

    // R7: an uncompressed boundary needs a pending empty packet and consumes it
    p_raw_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.open && !ctl_q.mode) |-> ctl_q.flag);
    p_raw_clears_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.open && !ctl_q.mode) |=> !ctl_q.flag);

    // R8: an empty packet leaves the flag set while the mode holds
    p_empty_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tag.empty && (compress_en == ctl_q.mode)) |=> ctl_q.flag);

    // R9: a mode change discards the pending end of frame
    p_mode_change_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (compress_en != ctl_q.mode) |=> !ctl_q.flag);

endmodule

// File: rtl/fd_emit.sv
module fd_emit #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  fd_pkg::fd_evt_t       evt,
    input  logic [DATA_W-1:0]     s_data,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_data,
    output logic                  out_close,
    output logic                  out_open,
    output logic                  hdr_req
);
    import fd_pkg::*;

    fd_evt_t             ev_d, ev_q;
    logic [DATA_W-1:0]   dat_d, dat_q;

    always_comb begin
        ev_d  = evt;
        dat_d = evt.valid ? s_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_q  <= '0;
            dat_q <= '0;
        end else begin
            ev_q  <= ev_d;
            dat_q <= dat_d;
        end
    end

    assign out_valid = ev_q.valid;
    assign out_data  = dat_q;
    assign out_close = ev_q.close;
    assign out_open  = ev_q.open;
    assign hdr_req   = ev_q.hdr;

    // R7: close and open always travel as a pair
    p_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_close == out_open);

    // R4: a header request beat forwards no marker byte
    p_hdr_no_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req |-> (out_open && !out_valid));

endmodule

// File: rtl/fd_frame_delim.sv
module fd_frame_delim #(
    parameter int                DATA_W = 8,
    parameter logic [DATA_W-1:0] SOI_HI = 8'hFF,
    parameter logic [DATA_W-1:0] SOI_LO = 8'hD8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              compress_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_empty,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_close,
    output logic              out_open,
    output logic              hdr_req
);
    import fd_pkg::*;

    fd_tag_t           s_tag;
    logic [DATA_W-1:0] s_data;
    fd_evt_t           evt;
    logic              drop_next;

    fd_stage #(.DATA_W(DATA_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_empty  (in_empty),
        .drop_next (drop_next),
        .s_tag     (s_tag),
        .s_data    (s_data)
    );

    fd_rules #(.DATA_W(DATA_W), .SOI_HI(SOI_HI), .SOI_LO(SOI_LO)) u_rules (
        .clk         (clk),
        .rst_n       (rst_n),
        .compress_en (compress_en),
        .s_tag       (s_tag),
        .s_data      (s_data),
        .in_valid    (in_valid),
        .in_sop      (in_sop),
        .in_data     (in_data),
        .evt         (evt),
        .drop_next   (drop_next)
    );

    fd_emit #(.DATA_W(DATA_W)) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .s_data    (s_data),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_close (out_close),
        .out_open  (out_open),
        .hdr_req   (hdr_req)
    );

    // R4: the beat after a header request is the dropped second marker byte
    p_second_marker_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_req |=> !out_valid);

    // R4: a marker detection marks the next held byte for dropping
    p_drop_marked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drop_next |=> (s_tag.drop && s_tag.valid));

endmodule

// File: tb/fd_frame_delim_test.sv
`timescale 1ns/1ps
module fd_frame_delim_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       compress_en = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_eop = 1'b0;
    logic       in_empty = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_close;
    logic       out_open;
    logic       hdr_req;

    always #2.5 clk = ~clk;

    fd_frame_delim uut (
        .clk(clk), .rst_n(rst_n), .compress_en(compress_en),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_empty(in_empty),
        .out_valid(out_valid), .out_data(out_data), .out_close(out_close),
        .out_open(out_open), .hdr_req(hdr_req)
    );

    typedef struct {
        bit       close;
        bit       open;
        bit       hdr;
        bit       valid;
        bit [7:0] data;
    } beat_t;

    beat_t eq[$];
    string tq[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    m_mode = 0;
    bit    m_flag = 0;

    function automatic beat_t quiet();
        beat_t b;
        b.close = 0; b.open = 0; b.hdr = 0; b.valid = 0; b.data = 0;
        return b;
    endfunction

    task automatic check_out();
        if (eq.size() == 2) begin
            beat_t x;
            string t;
            bit    bad;
            x = eq.pop_front();
            t = tq.pop_front();
            n_cmp++;
            bad = (out_close !== x.close) || (out_open !== x.open) ||
                  (hdr_req !== x.hdr) || (out_valid !== x.valid) ||
                  (x.valid && (out_data !== x.data));
            if (bad) begin
                n_bad++;
                $display("FAIL %s: got close=%b open=%b hdr=%b valid=%b data=%h, expected close=%b open=%b hdr=%b valid=%b data=%h",
                         t, out_close, out_open, hdr_req, out_valid, out_data,
                         x.close, x.open, x.hdr, x.valid, x.data);
            end
        end
    endtask

    task automatic cyc(bit v, bit [7:0] d, bit s, bit e, bit em, beat_t x, string tag);
        @(negedge clk);
        check_out();
        in_valid = v; in_data = d; in_sop = s; in_eop = e; in_empty = em;
        eq.push_back(x);
        tq.push_back(tag);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 0, 0, 0, quiet(), tag);
    endtask

    task automatic send_empty(string tag);
        cyc(0, 8'h00, 0, 0, 1, quiet(), tag);
        m_flag = 1;
    endtask

    task automatic set_mode(bit m, string tag);
        @(negedge clk);
        check_out();
        compress_en = m;
        in_valid = 0; in_sop = 0; in_eop = 0; in_empty = 0;
        eq.push_back(quiet());
        tq.push_back(tag);
        if (m != m_mode) m_flag = 0;
        m_mode = m;
    endtask

    task automatic send_pkt(logic [7:0] p[], string tag);
        int  n;
        bit  raw_b;
        bit  soi_b;
        n     = p.size();
        raw_b = !m_mode && m_flag;
        soi_b = m_mode && n >= 2 && p[0] == 8'hFF && p[1] == 8'hD8;
        for (int i = 0; i < n; i++) begin
            beat_t x;
            x = quiet();
            if (i == 0 && (raw_b || soi_b)) begin
                x.close = 1; x.open = 1; x.hdr = soi_b;
            end
            if (!(soi_b && i < 2)) begin
                x.valid = 1; x.data = p[i];
            end
            cyc(1, p[i], i == 0, i == n - 1, 0, x, tag);
        end
        if (raw_b) m_flag = 0;
    endtask

    task automatic do_reset(string tag);
        idle(3, tag);
        @(negedge clk);
        rst_n = 0;
        in_valid = 0; in_sop = 0; in_eop = 0; in_empty = 0;
        eq.delete();
        tq.delete();
        m_flag = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_cmp++;
            if (out_valid || out_close || out_open || hdr_req || out_data != 0) begin
                n_bad++;
                $display("FAIL %s: reset outputs valid=%b close=%b open=%b hdr=%b data=%h, expected all 0",
                         tag, out_valid, out_close, out_open, hdr_req, out_data);
            end
        end
        rst_n = 1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2: watchdog expired, got no end of run, expected end within limit");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        // R1: outputs held at 0 in reset
        do_reset("R1");

        // uncompressed mode
        send_pkt('{8'h01, 8'h02, 8'h03}, "R2");
        send_empty("R7");
        send_pkt('{8'h04, 8'h05}, "R7");
        send_pkt('{8'h06}, "R7");
        send_empty("R8");
        send_empty("R8");
        send_empty("R8");
        send_pkt('{8'h07, 8'h08}, "R8");
        send_pkt('{8'h09}, "R8");
        send_pkt('{8'hFF, 8'hD8, 8'h11}, "R10");
        send_empty("R9");
        set_mode(1, "R9");
        set_mode(0, "R9");
        send_pkt('{8'h12, 8'h13}, "R9");

        // R1: reset discards a pending empty packet
        send_empty("R1");
        do_reset("R1");
        send_pkt('{8'h14, 8'h15}, "R1");

        // compressed mode
        set_mode(1, "R3");
        send_pkt('{8'hFF, 8'hD8, 8'hA0, 8'hA1, 8'hA2}, "R3");
        send_pkt('{8'hB0, 8'hB1}, "R4");
        send_empty("R6");
        send_pkt('{8'hB2}, "R6");
        send_empty("R6");
        send_empty("R6");
        send_pkt('{8'hB3, 8'hB4}, "R6");
        send_pkt('{8'hFF, 8'hD8}, "R4");
        send_pkt('{8'hFF, 8'h00, 8'hC0}, "R5");
        send_pkt('{8'hFF}, "R5");
        send_pkt('{8'hD8, 8'hFF}, "R5");
        send_pkt('{8'h01, 8'hFF, 8'hD8, 8'h02}, "R11");
        send_pkt('{8'hFF, 8'hD8, 8'hFF, 8'hD8}, "R11");
        idle(2, "R2");
        send_pkt('{8'hFF, 8'hD8, 8'h5A}, "R3");

        // back to uncompressed: empty pending from compressed mode is gone
        send_empty("R9");
        set_mode(0, "R9");
        send_pkt('{8'h21, 8'h22}, "R9");
        send_empty("R7");
        send_pkt('{8'h23}, "R7");
        idle(4, "R2");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule